// File: doc/BRIEF.md
# Host Controller Command and Status Register

This block holds the 32-bit command and status word that a USB host controller shares between its driver software and its internal list-processing engine. Software reaches the word through a single-register read/write port. A write never clears anything: each 1 in the write data sets the matching command flag, and each 0 leaves that flag as it was. Software can therefore issue one command after another without a read-modify-write sequence.

The list-processing engine owns the other side of each flag handshake. It clears the host-reset flag when the reset finishes. It clears the ownership-request flag when the changeover completes. It clears a list-filled flag when it starts a pass over that list, and sets the flag again whenever it finds a transfer descriptor. A 2-bit counter records scheduling overruns, which occur when the periodic list does not finish within its frame. Every overrun also sends a one-cycle pulse to the interrupt status block. A second pulse output tells that block that software has just raised an ownership change request.

Top module: `hc_cmd_status`

## Requirements
- R1: After reset every bit of `regRdData` reads 0 and both pulse outputs are low.
- R2: A write with `regWrEn` high sets each flag in bits 3:0 whose write-data bit is 1. Flags whose write-data bit is 0 keep their value. The new value is visible on `regRdData` after the clock edge that samples the write.
- R3: Bits 31:18 and 15:4 always read 0, and writing 1s to them has no effect.
- R4: Bits 17:16 hold an overrun count. The count rises by one after each cycle in which `schedOverrun` is high, and wraps from 3 to 0. Software writes to bits 17:16 do not change it.
- R5: `overrunIrqSet` is high for exactly the cycle after each cycle in which `schedOverrun` is high. This happens on every event, whatever the count is.
- R6: Bit 3 (ownership request) is cleared by `ownChangeDone`. `ownChangeIrqSet` pulses for one cycle, in the cycle in which bit 3 first reads 1 after being 0. Rewriting bit 3 while it is already 1 gives no new pulse.
- R7: Bit 2 (bulk list filled) is cleared by `bulkListStart` and set by `bulkTdFound`. When both are high in the same cycle, the bit ends at 1.
- R8: Bit 1 (control list filled) follows the same handshake as bit 2, using `ctrlListStart` and `ctrlTdFound`.
- R9: Bit 0 (host controller reset) is cleared by `resetDone`.
- R10: When a software set and a hardware clear hit the same flag in the same cycle, the flag ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Write data; a 1 sets the matching flag |
| regRdData | output | 32 | Current register contents |
| schedOverrun | input | 1 | Scheduling overrun event |
| ownChangeDone | input | 1 | Ownership changeover completed |
| resetDone | input | 1 | Host controller reset completed |
| bulkListStart | input | 1 | Engine begins a bulk list pass |
| bulkTdFound | input | 1 | Descriptor found on the bulk list |
| ctrlListStart | input | 1 | Engine begins a control list pass |
| ctrlTdFound | input | 1 | Descriptor found on the control list |
| overrunIrqSet | output | 1 | Pulse that sets the overrun interrupt flag |
| ownChangeIrqSet | output | 1 | Pulse that sets the ownership change interrupt flag |

## Verification
The assertions check several rules on every cycle: reserved bits read zero, the counter moves by exactly one or holds, each overrun is followed by its interrupt pulse, the ownership pulse never lasts two cycles, and a software set always lands even when a hardware clear arrives in the same cycle. Other behaviour can only be shown by the bench's directed scenarios. These cover the wrap from 3 to 0, writes to the counter field being ignored, no repeated ownership pulse when the request is written again, the start-then-found sequence of a list pass, and a write of 0 leaving earlier commands in place.

// File: rtl/hc_cmd_pkg.sv
package hc_cmd_pkg;

  localparam int REG_W    = 32;
  localparam int SOC_W    = 2;
  localparam int SOC_LSB  = 16;
  localparam int FLAG_N   = 4;

  // flag positions, decoded by the list engine and the interrupt block
  localparam int FLAG_HCR = 0;
  localparam int FLAG_CLF = 1;
  localparam int FLAG_BLF = 2;
  localparam int FLAG_OCR = 3;

  // strobes from control to datapath for one cycle
  typedef struct packed {
    logic [FLAG_N-1:0] swSet;
    logic [FLAG_N-1:0] hwClr;
    logic [FLAG_N-1:0] hwSet;
    logic              socInc;
  } cmdStrobe_t;

endpackage

// File: rtl/hc_cmd_ctrl.sv
module hc_cmd_ctrl
  import hc_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_W-1:0]  regWrData,
  input  logic              schedOverrun,
  input  logic              ownChangeDone,
  input  logic              resetDone,
  input  logic              bulkListStart,
  input  logic              bulkTdFound,
  input  logic              ctrlListStart,
  input  logic              ctrlTdFound,
  input  logic [FLAG_N-1:0] flagRise,
  output cmdStrobe_t        strb,
  output logic              overrunIrqSet,
  output logic              ownChangeIrqSet
);

  always_comb begin
    strb.swSet  = regWrEn ? regWrData[FLAG_N-1:0] : '0;
    strb.hwClr  = '0;
    strb.hwSet  = '0;
    strb.hwClr[FLAG_HCR] = resetDone;
    strb.hwClr[FLAG_CLF] = ctrlListStart;
    strb.hwClr[FLAG_BLF] = bulkListStart;
    strb.hwClr[FLAG_OCR] = ownChangeDone;
    strb.hwSet[FLAG_CLF] = ctrlTdFound;
    strb.hwSet[FLAG_BLF] = bulkTdFound;
    strb.socInc = schedOverrun;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      overrunIrqSet   <= 1'b0;
      ownChangeIrqSet <= 1'b0;
    end else begin
      overrunIrqSet   <= schedOverrun;
      ownChangeIrqSet <= flagRise[FLAG_OCR];
    end
  end

endmodule

// File: rtl/hc_cmd_dp.sv
module hc_cmd_dp
  import hc_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  cmdStrobe_t        strb,
  output logic [FLAG_N-1:0] flagRise,
  output logic [REG_W-1:0]  rdData
);

  logic [FLAG_N-1:0] flagQ;
  logic [FLAG_N-1:0] flagNext;
  logic [SOC_W-1:0]  socQ;

  for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
    // a set from either side beats a clear
    assign flagNext[i] = (flagQ[i] & ~strb.hwClr[i]) | strb.hwSet[i] | strb.swSet[i];
    assign flagRise[i] = flagNext[i] & ~flagQ[i];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) flagQ[i] <= 1'b0;
      else       flagQ[i] <= flagNext[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            socQ <= '0;
    else if (strb.socInc) socQ <= socQ + 1'b1;
  end

  always_comb begin
    rdData                      = '0;
    rdData[SOC_LSB +: SOC_W]    = socQ;
    rdData[FLAG_N-1:0]          = flagQ;
  end

endmodule

// File: rtl/hc_cmd_status.sv
module hc_cmd_status
  import hc_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  logic              schedOverrun,
  input  logic              ownChangeDone,
  input  logic              resetDone,
  input  logic              bulkListStart,
  input  logic              bulkTdFound,
  input  logic              ctrlListStart,
  input  logic              ctrlTdFound,
  output logic              overrunIrqSet,
  output logic              ownChangeIrqSet
);

  cmdStrobe_t        strb;
  logic [FLAG_N-1:0] flagRise;

  hc_cmd_ctrl u_ctrl (
    .clk             (clk),
    .rstN            (rstN),
    .regWrEn         (regWrEn),
    .regWrData       (regWrData),
    .schedOverrun    (schedOverrun),
    .ownChangeDone   (ownChangeDone),
    .resetDone       (resetDone),
    .bulkListStart   (bulkListStart),
    .bulkTdFound     (bulkTdFound),
    .ctrlListStart   (ctrlListStart),
    .ctrlTdFound     (ctrlTdFound),
    .flagRise        (flagRise),
    .strb            (strb),
    .overrunIrqSet   (overrunIrqSet),
    .ownChangeIrqSet (ownChangeIrqSet)
  );

  hc_cmd_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .flagRise (flagRise),
    .rdData   (regRdData)
  );

endmodule

// File: rtl/hc_cmd_status_chk.sv
module hc_cmd_status_chk
  import hc_cmd_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [REG_W-1:0]  regWrData,
  input logic [REG_W-1:0]  regRdData,
  input logic              schedOverrun,
  input logic              ownChangeDone,
  input logic              resetDone,
  input logic              bulkListStart,
  input logic              bulkTdFound,
  input logic              ctrlListStart,
  input logic              ctrlTdFound,
  input logic              overrunIrqSet,
  input logic              ownChangeIrqSet
);

  localparam logic [REG_W-1:0] LIVE_MASK =
    (REG_W'((1 << SOC_W) - 1) << SOC_LSB) | REG_W'((1 << FLAG_N) - 1);

  logic [SOC_W-1:0] socView;
  assign socView = regRdData[SOC_LSB +: SOC_W];

  assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (regRdData & ~LIVE_MASK) == '0);

  assert_count_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    schedOverrun |=> socView == SOC_W'($past(socView) + 1'b1));

  assert_count_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !schedOverrun |=> $stable(socView));

  assert_overrun_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    schedOverrun |=> overrunIrqSet);

  assert_overrun_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    !schedOverrun |=> !overrunIrqSet);

  assert_own_pulse_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    ownChangeIrqSet |=> !ownChangeIrqSet);

  assert_own_pulse_flag_R6: assert property (@(posedge clk) disable iff (!rstN)
    ownChangeIrqSet |-> regRdData[FLAG_OCR]);

  assert_bulk_found_R7: assert property (@(posedge clk) disable iff (!rstN)
    bulkTdFound |=> regRdData[FLAG_BLF]);

  assert_ctrl_found_R8: assert property (@(posedge clk) disable iff (!rstN)
    ctrlTdFound |=> regRdData[FLAG_CLF]);

  for (genvar i = 0; i < FLAG_N; i++) begin : g_sw
    assert_sw_set_wins_R10: assert property (@(posedge clk) disable iff (!rstN)
      (regWrEn && regWrData[i]) |=> regRdData[i]);
  end

endmodule

bind hc_cmd_status hc_cmd_status_chk u_chk (.*);

// File: tb/hc_cmd_status_bench.sv
`timescale 1ns/1ps
module hc_cmd_status_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        schedOverrun = 1'b0;
  logic        ownChangeDone = 1'b0;
  logic        resetDone = 1'b0;
  logic        bulkListStart = 1'b0;
  logic        bulkTdFound = 1'b0;
  logic        ctrlListStart = 1'b0;
  logic        ctrlTdFound = 1'b0;
  logic        overrunIrqSet;
  logic        ownChangeIrqSet;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  hc_cmd_status u_hc_cmd_status (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock edge, then sample and drop all stimulus
  task automatic tick();
    @(posedge clk);
    #1;
    regWrEn = 1'b0; regWrData = '0;
    schedOverrun = 1'b0; ownChangeDone = 1'b0; resetDone = 1'b0;
    bulkListStart = 1'b0; bulkTdFound = 1'b0;
    ctrlListStart = 1'b0; ctrlTdFound = 1'b0;
  endtask

  task automatic wr(input logic [31:0] d);
    regWrEn = 1'b1; regWrData = d;
    tick();
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (2) @(posedge clk);
    #1 rstN = 1'b1;
    tick();
  endtask

  task automatic tResetState();
    doReset();
    chk("R1 rdData", regRdData, 32'h0);
    chk("R1 irq", {30'd0, overrunIrqSet, ownChangeIrqSet}, 32'h0);
  endtask

  task automatic tW1S();
    doReset();
    wr(32'h1);
    chk("R2 set bit0", regRdData, 32'h1);
    wr(32'h4);
    chk("R2 set bit2 keeps bit0", regRdData, 32'h5);
    wr(32'h0);
    chk("R2 zero write no change", regRdData, 32'h5);
  endtask

  task automatic tReserved();
    doReset();
    wr(32'hFFFC_FFF0);
    chk("R3 reserved ignored", regRdData, 32'h0);
    wr(32'h0003_0000);
    chk("R4 count not writable", regRdData, 32'h0);
  endtask

  task automatic tOverrun();
    doReset();
    for (int i = 1; i <= 5; i++) begin
      schedOverrun = 1'b1;
      tick();
      chk("R5 pulse", {31'd0, overrunIrqSet}, 32'h1);
      chk("R4 count", regRdData, 32'(i % 4) << 16);
    end
    tick();
    chk("R5 pulse drops", {31'd0, overrunIrqSet}, 32'h0);
    chk("R4 count holds", regRdData, 32'h0001_0000);
  endtask

  task automatic tOwnership();
    doReset();
    wr(32'h8);
    chk("R6 request set", regRdData, 32'h8);
    chk("R6 pulse on rise", {31'd0, ownChangeIrqSet}, 32'h1);
    tick();
    chk("R6 pulse one cycle", {31'd0, ownChangeIrqSet}, 32'h0);
    wr(32'h8);
    chk("R6 no repeat pulse", {31'd0, ownChangeIrqSet}, 32'h0);
    ownChangeDone = 1'b1;
    tick();
    chk("R6 cleared by done", regRdData, 32'h0);
    wr(32'h8);
    chk("R6 new pulse after clear", {31'd0, ownChangeIrqSet}, 32'h1);
  endtask

  task automatic tBulk();
    doReset();
    bulkListStart = 1'b1;
    tick();
    chk("R7 start on empty", regRdData, 32'h0);
    wr(32'h4);
    bulkListStart = 1'b1;
    tick();
    chk("R7 start clears", regRdData, 32'h0);
    bulkTdFound = 1'b1;
    tick();
    chk("R7 found sets", regRdData, 32'h4);
    bulkListStart = 1'b1; bulkTdFound = 1'b1;
    tick();
    chk("R7 start+found keeps 1", regRdData, 32'h4);
  endtask

  task automatic tCtrl();
    doReset();
    wr(32'h2);
    chk("R8 sw set", regRdData, 32'h2);
    ctrlListStart = 1'b1;
    tick();
    chk("R8 start clears", regRdData, 32'h0);
    ctrlTdFound = 1'b1;
    tick();
    chk("R8 found sets", regRdData, 32'h2);
  endtask

  task automatic tHcr();
    doReset();
    wr(32'h5);
    resetDone = 1'b1;
    tick();
    chk("R9 reset done clears bit0 only", regRdData, 32'h4);
  endtask

  task automatic tPriority();
    doReset();
    wr(32'hF);
    regWrEn = 1'b1; regWrData = 32'hD;
    resetDone = 1'b1; bulkListStart = 1'b1; ownChangeDone = 1'b1; ctrlListStart = 1'b1;
    tick();
    chk("R10 sw set beats clear", regRdData, 32'hD);
  endtask

  initial begin
    tResetState();
    tW1S();
    tReserved();
    tOverrun();
    tOwnership();
    tBulk();
    tCtrl();
    tHcr();
    tPriority();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule